// File: doc/BRIEF.md
# Rotating-Slot Pipeline Stage Sequencer

This block is the control sequencer for a four-stage in-order processor pipeline. It does not move instructions through fixed pipeline registers. Instead it keeps four execution slots, and each slot carries its own stage state through Fetch, Decode, Execute and Writeback. Each cycle the slots advance one stage. Slots that are not active wait in a chain of three idle states, so after reset they enter Fetch one cycle apart.

Three conditions change the normal advance:

- **Branch taken in Decode.** The slot holding the wrongly fetched instruction is parked in the first idle state. The slot in Writeback is parked in the second idle state. No flush is needed.
- **Memory operation in Execute.** Every slot is frozen for a short window.
- **Register read-after-write conflict in Decode.** Every slot is frozen for a longer window.

A halt input freezes all slots until the next reset. The datapath reads each slot's state code and a per-stage occupancy vector.

Top module: `slot_pipe_seq`

## Requirements
- R1: During and directly after reset, slot 0 is in Fetch and slots 1, 2 and 3 are in Idle0, Idle1 and Idle2. The state codes are Fetch=0, Decode=1, Execute=2, Writeback=3, Idle0=4, Idle1=5 and Idle2=6. Slot i occupies bits [3i+2:3i] of `slot_state_o`.
- R2: On a normal advance, an active slot moves Fetch→Decode→Execute→Writeback→Fetch.
- R3: On an advance, an idle slot moves Idle0→Idle1→Idle2. A slot in Idle2 moves to Fetch only if no slot is in Writeback and no branch is applied in that cycle. When several slots are in Idle2, only the lowest-numbered one moves. Otherwise the slot stays in Idle2.
- R4: `branch_taken_i` takes effect only while some slot is in Decode and the sequencer is advancing. In that cycle the Fetch slot moves to Idle0 and the Writeback slot moves to Idle1. The Decode and Execute slots advance normally. In the next cycle no slot is in Fetch.
- R5: A memory request (`mem_exec_i`) accepted with no branch applied freezes all slots for MEM_HOLD cycles (default 1), counting the request cycle.
- R6: A hazard request (`raw_hazard_i`) accepted with no branch applied freezes all slots for HAZ_HOLD cycles (default 2), counting the request cycle.
- R7: When both requests arrive in the same cycle, the larger of MEM_HOLD and HAZ_HOLD sets the freeze length.
- R8: While a freeze window is still running, new stall requests and `branch_taken_i` are ignored.
- R9: When a stall request arrives in the same cycle as an applied branch, the branch advance happens first. The freeze then lasts the full hold length, starting with the next cycle.
- R10: Asserting `halt_i` freezes every slot from that cycle on until reset.
- R11: At no time is more than one slot in any one of the four stages.
- R12: Bit s of `stage_valid_o` (bit 0 = Fetch up to bit 3 = Writeback) is 1 exactly when some slot holds stage s. Both outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| branch_taken_i | input | 1 | Branch resolved taken in Decode |
| mem_exec_i | input | 1 | Memory instruction occupies Execute |
| raw_hazard_i | input | 1 | Read-after-write conflict seen in Decode |
| halt_i | input | 1 | Halt instruction reached Writeback |
| slot_state_o | output | 12 | Per-slot 3-bit state codes |
| stage_valid_o | output | 4 | Per-stage occupancy, Fetch in bit 0 |

## Verification
The bench builds the block with its defaults, MEM_HOLD=1 and HAZ_HOLD=2. With these values the two freeze lengths differ, so the larger-wins rule (R7) shows up as a one-cycle difference. A request arriving during a two-cycle hazard freeze lands while the window is still open, which exercises the ignore rule (R8). Random branches after idle slots have re-entered make several slots meet in Idle2 and wait behind a busy Writeback stage. This covers the lowest-index fetch entry rule and the uniqueness invariant.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  localparam int unsigned NUM_STAGES = 4;
  localparam int unsigned NUM_SLOTS  = NUM_STAGES;
  localparam int unsigned CODE_W     = 3;

  typedef enum logic [CODE_W-1:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_WBACK  = 3'd3,
    ST_IDLE0  = 3'd4,
    ST_IDLE1  = 3'd5,
    ST_IDLE2  = 3'd6
  } slot_st_e;

  // Freeze length chosen from the two request flags: the longer one wins.
  function automatic int unsigned pick_hold(input logic mem, input logic haz,
                                            input int unsigned mem_len,
                                            input int unsigned haz_len);
    int unsigned a;
    int unsigned b;
    a = mem ? mem_len : 0;
    b = haz ? haz_len : 0;
    return (a > b) ? a : b;
  endfunction

  // One advance step of a single slot.
  function automatic slot_st_e advance_state(input slot_st_e cur,
                                             input logic redirect,
                                             input logic fetch_grant);
    slot_st_e nxt;
    case (cur)
      ST_FETCH:  nxt = redirect ? ST_IDLE0 : ST_DECODE;
      ST_DECODE: nxt = ST_EXEC;
      ST_EXEC:   nxt = ST_WBACK;
      ST_WBACK:  nxt = redirect ? ST_IDLE1 : ST_FETCH;
      ST_IDLE0:  nxt = ST_IDLE1;
      ST_IDLE1:  nxt = ST_IDLE2;
      ST_IDLE2:  nxt = fetch_grant ? ST_FETCH : ST_IDLE2;
      default:   nxt = ST_IDLE2;
    endcase
    return nxt;
  endfunction

  // Reset placement: slot 0 fetches, the others wait in staggered idle states.
  function automatic slot_st_e reset_state(input int unsigned idx);
    if (idx == 0) return ST_FETCH;
    return slot_st_e'(CODE_W'(int'(ST_IDLE0) + int'(idx) - 1));
  endfunction

endpackage

// File: rtl/stall_ctrl.sv
module stall_ctrl import slot_seq_pkg::*; #(
  parameter int unsigned MEM_HOLD = 1,
  parameter int unsigned HAZ_HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  input  logic mem_req_i,
  input  logic haz_req_i,
  input  logic branch_fire_i,
  output logic busy_o,
  output logic accept_o,
  output logic hold_o
);

  localparam int unsigned MAX_HOLD = (MEM_HOLD > HAZ_HOLD) ? MEM_HOLD : HAZ_HOLD;
  localparam int unsigned CNT_W    = (MAX_HOLD < 2) ? 1 : $clog2(MAX_HOLD + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] req_len;

  assign req_len  = CNT_W'(pick_hold(mem_req_i, haz_req_i, MEM_HOLD, HAZ_HOLD));
  assign busy_o   = (cnt_q != '0);
  assign accept_o = !freeze_i && !busy_o && (req_len != '0);
  assign hold_o   = busy_o || (accept_o && !branch_fire_i);

  always_comb begin
    cnt_d = '0;
    if (freeze_i)      cnt_d = cnt_q;
    else if (busy_o)   cnt_d = cnt_q - 1'b1;
    else if (accept_o) cnt_d = branch_fire_i ? req_len : req_len - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R7: the window never exceeds the longest configured hold
  assert_hold_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_HOLD));

  // R8: a running window only counts down, whatever requests arrive
  assert_busy_counts_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !freeze_i) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/fetch_arb.sv
module fetch_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         block_i,
  output logic [N-1:0] grant_o
);

  logic [N:0] taken;

  assign taken[0] = block_i;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] && !taken[i];
    assign taken[i+1]  = taken[i] || req_i[i];
  end

  // R3: at most one idle slot may enter Fetch per cycle
  assert_single_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R3: nothing enters Fetch from idle while blocked
  assert_blocked_no_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |-> (grant_o == '0));

endmodule

// File: rtl/slot_cell.sv
module slot_cell import slot_seq_pkg::*; #(
  parameter int unsigned IDX = 0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     advance_i,
  input  logic     redirect_i,
  input  logic     grant_i,
  output slot_st_e state_o,
  output slot_st_e next_o
);

  localparam slot_st_e RST_ST = reset_state(IDX);

  always_comb begin
    next_o = state_o;
    if (advance_i) next_o = advance_state(state_o, redirect_i, grant_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_o <= RST_ST;
    else         state_o <= next_o;
  end

  // R3: idle chain steps forward on every advance
  assert_idle_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE0 && advance_i) |=> (state_o == ST_IDLE1));

  // R2: an executing slot always reaches Writeback next on advance
  assert_exec_to_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_EXEC && advance_i) |=> (state_o == ST_WBACK));

endmodule

// File: rtl/slot_pipe_seq.sv
module slot_pipe_seq import slot_seq_pkg::*; #(
  parameter int unsigned MEM_HOLD = 1,
  parameter int unsigned HAZ_HOLD = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        branch_taken_i,
  input  logic                        mem_exec_i,
  input  logic                        raw_hazard_i,
  input  logic                        halt_i,
  output logic [CODE_W*NUM_SLOTS-1:0] slot_state_o,
  output logic [NUM_STAGES-1:0]       stage_valid_o
);

  slot_st_e slot_q [NUM_SLOTS];
  slot_st_e slot_d [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] occ_now  [NUM_STAGES];
  logic [NUM_SLOTS-1:0] occ_next [NUM_STAGES];
  logic [NUM_STAGES-1:0] valid_d;
  logic [NUM_SLOTS-1:0] idle2_vec;
  logic [NUM_SLOTS-1:0] fetch_grant;

  logic halted_q;
  logic freeze;
  logic stall_busy, stall_accept, stall_hold;
  logic has_decode, wb_occupied;
  logic branch_fire;
  logic advance;

  // Occupancy views of current and next slot states
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign occ_now[s][i]  = (slot_q[i] == slot_st_e'(CODE_W'(s)));
      assign occ_next[s][i] = (slot_d[i] == slot_st_e'(CODE_W'(s)));
    end
    assign valid_d[s] = |occ_next[s];
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_idle
    assign idle2_vec[i] = (slot_q[i] == ST_IDLE2);
  end

  assign has_decode  = |occ_now[int'(ST_DECODE)];
  assign wb_occupied = |occ_now[int'(ST_WBACK)];
  assign freeze      = halted_q || halt_i;
  assign branch_fire = branch_taken_i && has_decode && !freeze && !stall_busy;
  assign advance     = !freeze && !stall_hold;

  stall_ctrl #(
    .MEM_HOLD (MEM_HOLD),
    .HAZ_HOLD (HAZ_HOLD)
  ) u_stall (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .freeze_i      (freeze),
    .mem_req_i     (mem_exec_i),
    .haz_req_i     (raw_hazard_i),
    .branch_fire_i (branch_fire),
    .busy_o        (stall_busy),
    .accept_o      (stall_accept),
    .hold_o        (stall_hold)
  );

  fetch_arb #(.N(NUM_SLOTS)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (idle2_vec),
    .block_i (wb_occupied || branch_fire),
    .grant_o (fetch_grant)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cell
    slot_cell #(.IDX(i)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .advance_i  (advance),
      .redirect_i (branch_fire),
      .grant_i    (fetch_grant[i]),
      .state_o    (slot_q[i]),
      .next_o     (slot_d[i])
    );
    assign slot_state_o[CODE_W*i +: CODE_W] = slot_q[i];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      halted_q      <= 1'b0;
      stage_valid_o <= NUM_STAGES'(1);
    end else begin
      halted_q      <= freeze;
      stage_valid_o <= valid_d;
    end
  end

  // R11: each stage holds at most one slot
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_chk
    assert_stage_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(occ_now[s]) <= 1);
    // R12: registered valid bit tracks slot occupancy
    assert_valid_tracks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_valid_o[s] == (|occ_now[s]));
  end

  // R3: an Idle2 slot stays put while Writeback is busy
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_idle_chk
    assert_idle_waits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_q[i] == ST_IDLE2 && wb_occupied) |=> (slot_q[i] != ST_FETCH));
  end

  // R4: after a redirect the Fetch stage is empty for a cycle
  assert_branch_bubble_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_fire |=> !stage_valid_o[int'(ST_FETCH)]);

  // R5/R6: an accepted stall without branch freezes the slots
  assert_stall_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_accept && !branch_fire) |=> $stable(slot_state_o));

  // R8: a running window keeps every slot still
  assert_busy_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_busy |=> $stable(slot_state_o));

  // R10: once halted, stays halted with frozen slots
  assert_halt_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && $stable(slot_state_o)));

endmodule

// File: tb/slot_pipe_seq_tb_top.sv
`timescale 1ns/1ps
module slot_pipe_seq_tb_top;

  localparam int MEM_LEN = 1;
  localparam int HAZ_LEN = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic branch_taken_i = 1'b0;
  logic mem_exec_i = 1'b0;
  logic raw_hazard_i = 1'b0;
  logic halt_i = 1'b0;
  logic [11:0] slot_state_o;
  logic [3:0]  stage_valid_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int m_st [4];
  int m_cnt;
  bit m_halt;

  always #10 clk_i = ~clk_i;

  slot_pipe_seq #(.MEM_HOLD(MEM_LEN), .HAZ_HOLD(HAZ_LEN)) dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .branch_taken_i (branch_taken_i),
    .mem_exec_i     (mem_exec_i),
    .raw_hazard_i   (raw_hazard_i),
    .halt_i         (halt_i),
    .slot_state_o   (slot_state_o),
    .stage_valid_o  (stage_valid_o)
  );

  function automatic int step_one(int cur, bit br, bit gr);
    if (cur < 4) begin
      if (br && cur == 0) return 4;
      if (br && cur == 3) return 5;
      return (cur + 1) % 4;
    end
    if (cur == 6) return gr ? 0 : 6;
    return cur + 1;
  endfunction

  function automatic int hold_len(bit m, bit h);
    int a = m ? MEM_LEN : 0;
    int b = h ? HAZ_LEN : 0;
    return (a >= b) ? a : b;
  endfunction

  function automatic logic [11:0] pack_model();
    logic [11:0] v = '0;
    for (int i = 0; i < 4; i++) v[3*i +: 3] = 3'(m_st[i]);
    return v;
  endfunction

  function automatic logic [3:0] model_valid();
    logic [3:0] v = '0;
    for (int i = 0; i < 4; i++) if (m_st[i] < 4) v[m_st[i]] = 1'b1;
    return v;
  endfunction

  task automatic model_reset();
    m_st[0] = 0; m_st[1] = 4; m_st[2] = 5; m_st[3] = 6;
    m_cnt = 0; m_halt = 0;
  endtask

  task automatic model_step(bit b, bit m, bit h, bit hl);
    int len;
    bit hasd, wfull, br, given;
    int nx [4];
    if (m_halt || hl) begin m_halt = 1; return; end
    if (m_cnt > 0) begin m_cnt--; return; end
    len = hold_len(m, h);
    hasd = 0; wfull = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_st[i] == 1) hasd = 1;
      if (m_st[i] == 3) wfull = 1;
    end
    br = b && hasd;
    if (len > 0 && !br) begin m_cnt = len - 1; return; end
    m_cnt = len;
    given = wfull || br;
    for (int i = 0; i < 4; i++) begin
      bit g = 0;
      if (m_st[i] == 6 && !given) begin g = 1; given = 1; end
      nx[i] = step_one(m_st[i], br, g);
    end
    for (int i = 0; i < 4; i++) m_st[i] = nx[i];
  endtask

  task automatic check12(string tag, logic [11:0] act, logic [11:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: slot_state_o actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: stage_valid_o actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    int cnt [4];
    check12(tag, slot_state_o, pack_model());
    check4(tag, stage_valid_o, model_valid());
    for (int s = 0; s < 4; s++) cnt[s] = 0;
    for (int i = 0; i < 4; i++)
      if (slot_state_o[3*i +: 3] < 3'd4) cnt[slot_state_o[3*i +: 3]]++;
    compared++;
    for (int s = 0; s < 4; s++)
      if (cnt[s] > 1) begin
        mismatched++;
        $display("FAIL R11: stage %0d holds %0d slots, expected at most 1", s, cnt[s]);
        break;
      end
  endtask

  // Called at a negedge; returns at the next negedge after one clock edge.
  task automatic step(string tag, bit b, bit m, bit h, bit hl);
    branch_taken_i = b; mem_exec_i = m; raw_hazard_i = h; halt_i = hl;
    model_step(b, m, h, hl);
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    branch_taken_i = 0; mem_exec_i = 0; raw_hazard_i = 0; halt_i = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] held;
    void'($urandom(32'd20240611));
    @(negedge clk_i);
    do_reset();

    // R1: reset placement
    check12("R1", slot_state_o, 12'hD60);
    check4("R1", stage_valid_o, 4'b0001);

    // R2 R3: staggered fill to a full pipeline
    for (int k = 0; k < 4; k++) step("R2 R3 fill", 0, 0, 0, 0);
    check12("R2", slot_state_o, 12'h688);
    check4("R2", stage_valid_o, 4'b1111);

    // R4: branch parks Fetch slot in Idle0 and Writeback slot in Idle1
    step("R4", 1, 0, 0, 0);
    check12("R4", slot_state_o, 12'hAD4);
    check4("R4", stage_valid_o, 4'b1100);
    for (int k = 0; k < 6; k++) step("R3 refill", 0, 0, 0, 0);

    // R5: memory stall holds one cycle
    held = slot_state_o;
    step("R5", 0, 1, 0, 0);
    check12("R5 hold", slot_state_o, held);
    step("R5 resume", 0, 0, 0, 0);

    // R6 and R8: hazard holds two cycles; requests during the window are ignored
    held = slot_state_o;
    step("R6", 0, 0, 1, 0);
    check12("R6 hold1", slot_state_o, held);
    step("R8", 1, 1, 1, 0);
    check12("R8 hold2", slot_state_o, held);
    step("R8 resume", 0, 0, 0, 0);

    // R7: both requests, the longer wins
    held = slot_state_o;
    step("R7", 0, 1, 1, 0);
    step("R7", 0, 0, 0, 0);
    check12("R7 hold2", slot_state_o, held);
    step("R7 resume", 0, 0, 0, 0);

    // R9: branch and hazard together; branch first, then the hold
    for (int k = 0; k < 4; k++) step("R9 prep", 0, 0, 0, 0);
    step("R9 branch", 1, 0, 1, 0);
    held = slot_state_o;
    step("R9 hold1", 0, 0, 0, 0);
    step("R9 hold2", 0, 0, 0, 0);
    check12("R9 held", slot_state_o, held);
    step("R9 resume", 0, 0, 0, 0);

    // Random phase: R2 R3 R4 R5 R6 R7 R8 R9 R11 R12
    for (int k = 0; k < 4000; k++) begin
      bit b = ($urandom % 100) < 25;
      bit m = ($urandom % 100) < 10;
      bit h = ($urandom % 100) < 8;
      step("R2 R3 R4 R5 R6 R7 R8 R9 R11 R12 random", b, m, h, 0);
      if (k % 997 == 996) begin
        do_reset();
        compare_all("R1 rereset");
      end
    end

    // R10: halt freezes until reset
    step("R10 halt", 0, 0, 0, 1);
    held = slot_state_o;
    for (int k = 0; k < 8; k++) begin
      bit b = $urandom % 2;
      bit m = $urandom % 2;
      bit h = $urandom % 2;
      step("R10 frozen", b, m, h, 0);
      check12("R10", slot_state_o, held);
    end
    do_reset();
    check12("R1 R10 after reset", slot_state_o, 12'hD60);
    step("R2 after halt", 0, 0, 0, 0);

    finish_run();
  end

endmodule